// File: doc/BRIEF.md
# Parallel Order Scorer for Bayesian-Network Sampling

This block computes the log-domain score of one proposed variable ordering. A sampler uses it inside its propose/accept loop. Each variable (node) has its own small table of candidate parent sets, and each set has a precomputed local log score. The host fills these tables through a write port before sampling begins. When the sampler presents an ordering and pulses `start`, every node works in its own lane at the same time. A lane walks through its candidate sets one per cycle and keeps only the sets whose parents all come earlier in the ordering. It merges their scores with a log-sum-exp step: the larger of the two values plus a small correction read from a table.

When all lanes have finished, the node scores are added as plain fixed-point numbers. The sum is presented on `total_score` together with a one-cycle `done` pulse. Scores are signed fixed point with four fractional bits, so one unit of log probability is 16 LSBs. The ordering input is a packed list of node indices by position. The block assumes that this list is a permutation.

Top module: `os_order_scorer`

## Requirements
- R1: After reset, `done` is low, `total_score` is zero and every table slot is empty. A scoring run on an empty table therefore yields N_NODES times the minimum node score.
- R2: Field p of `order` (bits p*IDW up to p*IDW+IDW-1) holds the node at position p. Bit j of a parent mask stands for node j. A set is compatible with node v when it is valid and every bit set in its mask names a node at an earlier position than v.
- R3: A set whose mask names v itself, or any node at a later position than v, takes no part in v's score. A set with an empty mask is compatible with any node.
- R4: A node's score starts from its first compatible set, in ascending slot order, taken unchanged. Each further compatible set s is merged with the running value a as follows:
  - hi = max(a,s) and d = |a-s| in LSBs.
  - The result is hi + c. The correction c is round(16*ln(1+exp(-x))), where x = 0.5*floor(d/8) + 0.25.
  - c is 0 when d >= 64.
- R5: A node with no compatible set scores the minimum signed value, -2^(SCORE_W-1).
- R6: `total_score` is the sign-extended plain sum of all node scores, SCORE_W+clog2(N_NODES) bits wide. It changes only together with `done` and holds its value until the next `done`.
- R7: `done` is high for exactly one cycle per accepted run.
- R8: `start` is accepted at a clock edge when the block is idle. `done` is then high during the cycle that follows the SETS+1-th edge after the accepting edge.
- R9: `start` and `order` have no effect while a run is in progress. The result is that of the ordering captured when the run was accepted, and only one `done` pulse appears.
- R10: A write with `wr_en` high replaces slot `wr_slot` of node `wr_node` in the next cycle. `wr_valid` low empties that slot, so it is never compatible.
- R11: A log-sum merge that would exceed 2^(SCORE_W-1)-1 saturates at that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_node | input | IDW | Node whose table is written |
| wr_slot | input | SLW | Slot within that node's table |
| wr_valid | input | 1 | 1 fills the slot, 0 empties it |
| wr_mask | input | N_NODES | Parent-set mask, bit j = node j |
| wr_score | input | SCORE_W | Signed local log score, 4 fractional bits |
| start | input | 1 | Begin scoring the presented ordering |
| order | input | N_NODES*IDW | Node index at each position, position 0 in the low field |
| done | output | 1 | One-cycle result strobe |
| total_score | output | SCORE_W+clog2(N_NODES) | Signed order score |

## Verification
The bench builds the block with four nodes, four slots per node and 16-bit scores. With this setting, all 24 orderings of a mixed table can be swept, and each result is compared with a sum computed in the bench using real-valued logarithms. The small widths also put the saturation corner and the all-empty floor (four minimum scores in an 18-bit sum) within reach with a handful of writes. Slot removal, rewrites, self-referencing and later-node masks, and a second `start` in the middle of a run are each checked through the total score.

// File: rtl/os_pkg.sv
// Shared definitions for the order scorer.
// Assumes scores carry four fractional bits; the correction buckets are half
// a log unit wide and cover differences below four log units.
package os_pkg;

    localparam int FRAC_BITS    = 4;
    localparam int BUCKET_SHIFT = 3;
    localparam int CORR_SPAN    = 64;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SCAN = 2'd1,
        PH_SUM  = 2'd2
    } phase_t;

    // Correction ln(1+e^-x) in LSBs, sampled at the centre of each half-unit bucket.
    function automatic logic [3:0] corr_bucket(input logic [2:0] b);
        case (b)
            3'd0:    return 4'd9;
            3'd1:    return 4'd6;
            3'd2:    return 4'd4;
            3'd3:    return 4'd3;
            3'd4:    return 4'd2;
            3'd5:    return 4'd1;
            3'd6:    return 4'd1;
            default: return 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/os_pred_builder.sv
// Builds, for every node, the mask of nodes placed before it in the ordering.
// Assumes the ordering is a permutation; purely combinational.
module os_pred_builder #(
    parameter int N_NODES = 4,
    localparam int IDW = (N_NODES > 1) ? $clog2(N_NODES) : 1
) (
    input  logic [N_NODES*IDW-1:0]            order,
    output logic [N_NODES-1:0][N_NODES-1:0]   pred
);

    logic [N_NODES-1:0] seen;
    logic [IDW-1:0]     node_at;

    // Walk positions in order, handing each node the set of nodes already seen.
    always_comb begin
        seen    = '0;
        pred    = '0;
        node_at = '0;
        for (int p = 0; p < N_NODES; p++) begin
            node_at = order[p*IDW +: IDW];
            for (int v = 0; v < N_NODES; v++) begin
                if (node_at == IDW'(v)) begin
                    pred[v] = seen;
                end
            end
            seen[node_at] = 1'b1;
        end
    end

endmodule

// File: rtl/os_ctrl.sv
// Sequencer: idle, one scan cycle per table slot, one summing cycle.
// Assumes SETS >= 1; start is only taken while idle.
module os_ctrl #(
    parameter int SETS = 4,
    localparam int SLW = (SETS > 1) ? $clog2(SETS) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    output logic           accept,
    output logic           scan,
    output logic           finish,
    output logic           busy,
    output logic [SLW-1:0] slot
);
    import os_pkg::*;

    localparam logic [SLW-1:0] LAST_SLOT = SLW'(SETS - 1);

    phase_t phase;

    // Decode the phase into strobes for the datapath.
    always_comb begin
        accept = (phase == PH_IDLE) && start;
        scan   = (phase == PH_SCAN);
        finish = (phase == PH_SUM);
        busy   = (phase != PH_IDLE);
    end

    // Advance the phase and the slot counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            slot  <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    slot <= '0;
                    if (start) phase <= PH_SCAN;
                end
                PH_SCAN: begin
                    if (slot == LAST_SLOT) begin
                        phase <= PH_SUM;
                    end else begin
                        slot <= slot + 1'b1;
                    end
                end
                PH_SUM:  phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/os_lane.sv
// One node's lane: holds its candidate parent-set table and accumulates the
// log-sum of the compatible sets, one slot per step.
// Assumes SCORE_W >= 8 so the bucket bits of the difference exist.
module os_lane #(
    parameter int N_NODES = 4,
    parameter int SETS    = 4,
    parameter int SCORE_W = 16,
    localparam int SLW = (SETS > 1) ? $clog2(SETS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [SLW-1:0]            wr_slot,
    input  logic                      wr_valid,
    input  logic [N_NODES-1:0]        wr_mask,
    input  logic signed [SCORE_W-1:0] wr_score,
    input  logic [N_NODES-1:0]        pred,
    input  logic                      clear,
    input  logic                      step,
    input  logic [SLW-1:0]            slot,
    output logic signed [SCORE_W-1:0] node_score
);
    import os_pkg::*;

    localparam logic signed [SCORE_W-1:0] MIN_SCORE = {1'b1, {(SCORE_W-1){1'b0}}};
    localparam logic signed [SCORE_W:0]   MAX_X     = {2'b00, {(SCORE_W-1){1'b1}}};

    logic                      slot_valid [SETS];
    logic [N_NODES-1:0]        slot_mask  [SETS];
    logic signed [SCORE_W-1:0] slot_score [SETS];

    logic                      have;
    logic signed [SCORE_W-1:0] acc;

    logic                      compat;
    logic signed [SCORE_W-1:0] cur_score;
    logic signed [SCORE_W:0]   a_x, b_x, hi, lo, sum_x;
    logic [SCORE_W:0]          gap;
    logic [3:0]                corr;
    logic signed [SCORE_W-1:0] merged;

    // Host writes fill or empty one slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                slot_valid[s] <= 1'b0;
                slot_mask[s]  <= '0;
                slot_score[s] <= '0;
            end
        end else if (wr_en) begin
            slot_valid[wr_slot] <= wr_valid;
            slot_mask[wr_slot]  <= wr_mask;
            slot_score[wr_slot] <= wr_score;
        end
    end

    // Compatibility of the current slot with this node's predecessors.
    always_comb begin
        cur_score = slot_score[slot];
        compat    = slot_valid[slot] && ((slot_mask[slot] & ~pred) == '0);
    end

    // Log-sum merge: larger operand plus bucketed correction, saturated.
    always_comb begin
        a_x = {acc[SCORE_W-1], acc};
        b_x = {cur_score[SCORE_W-1], cur_score};
        if (a_x >= b_x) begin
            hi = a_x;
            lo = b_x;
        end else begin
            hi = b_x;
            lo = a_x;
        end
        gap = hi - lo;
        if (gap >= (SCORE_W+1)'(CORR_SPAN)) begin
            corr = 4'd0;
        end else begin
            corr = corr_bucket(gap[BUCKET_SHIFT +: 3]);
        end
        sum_x = hi + $signed({{(SCORE_W-3){1'b0}}, corr});
        if (sum_x > MAX_X) begin
            merged = MAX_X[SCORE_W-1:0];
        end else begin
            merged = sum_x[SCORE_W-1:0];
        end
    end

    // Running accumulator: first compatible set seeds it, later ones merge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have <= 1'b0;
            acc  <= MIN_SCORE;
        end else if (clear) begin
            have <= 1'b0;
            acc  <= MIN_SCORE;
        end else if (step && compat) begin
            have <= 1'b1;
            acc  <= have ? merged : cur_score;
        end
    end

    assign node_score = acc;

endmodule

// File: rtl/os_order_scorer.sv
// Top: parallel lanes score every node of a proposed ordering; the node
// scores are summed into the order score and reported with a done pulse.
// Assumes order is a permutation of 0..N_NODES-1.
module os_order_scorer #(
    parameter int N_NODES = 4,
    parameter int SETS    = 4,
    parameter int SCORE_W = 16,
    localparam int IDW   = (N_NODES > 1) ? $clog2(N_NODES) : 1,
    localparam int SLW   = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int SUM_W = SCORE_W + IDW
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDW-1:0]            wr_node,
    input  logic [SLW-1:0]            wr_slot,
    input  logic                      wr_valid,
    input  logic [N_NODES-1:0]        wr_mask,
    input  logic signed [SCORE_W-1:0] wr_score,
    input  logic                      start,
    input  logic [N_NODES*IDW-1:0]    order,
    output logic                      done,
    output logic signed [SUM_W-1:0]   total_score
);

    logic                              accept, scan, finish, busy;
    logic [SLW-1:0]                    slot;
    logic [N_NODES-1:0][N_NODES-1:0]   pred_next;
    logic [N_NODES-1:0][N_NODES-1:0]   pred_q;
    logic signed [SCORE_W-1:0]         lane_score [N_NODES];
    logic signed [SUM_W-1:0]           lane_sum;

    os_ctrl #(.SETS(SETS)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .accept (accept),
        .scan   (scan),
        .finish (finish),
        .busy   (busy),
        .slot   (slot)
    );

    os_pred_builder #(.N_NODES(N_NODES)) u_pred (
        .order (order),
        .pred  (pred_next)
    );

    // Capture the predecessor masks when a run is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_q <= '0;
        end else if (accept) begin
            pred_q <= pred_next;
        end
    end

    for (genvar g = 0; g < N_NODES; g++) begin : g_lane
        logic lane_wr;
        assign lane_wr = wr_en && (wr_node == IDW'(g));

        os_lane #(
            .N_NODES (N_NODES),
            .SETS    (SETS),
            .SCORE_W (SCORE_W)
        ) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (lane_wr),
            .wr_slot    (wr_slot),
            .wr_valid   (wr_valid),
            .wr_mask    (wr_mask),
            .wr_score   (wr_score),
            .pred       (pred_q[g]),
            .clear      (accept),
            .step       (scan),
            .slot       (slot),
            .node_score (lane_score[g])
        );
    end

    // Sign-extended plain sum of the lane results.
    always_comb begin
        lane_sum = '0;
        for (int n = 0; n < N_NODES; n++) begin
            lane_sum = lane_sum + SUM_W'(lane_score[n]);
        end
    end

    // Register the order score and strobe done in the summing cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total_score <= '0;
            done        <= 1'b0;
        end else begin
            done <= finish;
            if (finish) total_score <= lane_sum;
        end
    end

endmodule

// File: rtl/os_order_scorer_chk.sv
// Checker for the order scorer: pulse width, result hold, latency and
// stability of the captured ordering during a run.
module os_order_scorer_chk #(
    parameter int N_NODES = 4,
    parameter int SETS    = 4,
    parameter int SCORE_W = 16,
    localparam int IDW   = (N_NODES > 1) ? $clog2(N_NODES) : 1,
    localparam int SUM_W = SCORE_W + IDW
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            start,
    input logic                            busy,
    input logic                            done,
    input logic signed [SUM_W-1:0]         total_score,
    input logic [N_NODES-1:0][N_NODES-1:0] pred_q
);

    localparam logic [15:0] LAT = 16'(SETS + 1);

    logic [15:0] since_start;

    // Count cycles since the last accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_start <= '0;
        end else if (start && !busy) begin
            since_start <= 16'd1;
        end else if (done) begin
            since_start <= '0;
        end else if (since_start != '0) begin
            since_start <= since_start + 16'd1;
        end
    end

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_total_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(total_score));

    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (since_start == LAT + 16'd1));

    p_order_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(pred_q));

endmodule

bind os_order_scorer os_order_scorer_chk #(
    .N_NODES (N_NODES),
    .SETS    (SETS),
    .SCORE_W (SCORE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .total_score (total_score),
    .pred_q      (pred_q)
);

// File: tb/os_order_scorer_test.sv
`timescale 1ns/1ps
module os_order_scorer_test;
    localparam int N = 4, S = 4, W = 16, IDW = 2, SLW = 2, SUM_W = 18;
    localparam int LAT = S + 1;
    localparam int MINV = -32768, MAXV = 32767;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                  rst_n = 1'b0;
    logic                  wr_en = 1'b0;
    logic [IDW-1:0]        wr_node = '0;
    logic [SLW-1:0]        wr_slot = '0;
    logic                  wr_valid = 1'b0;
    logic [N-1:0]          wr_mask = '0;
    logic signed [W-1:0]   wr_score = '0;
    logic                  start = 1'b0;
    logic [N*IDW-1:0]      order = '0;
    logic                  done;
    logic signed [SUM_W-1:0] total_score;

    os_order_scorer #(.N_NODES(N), .SETS(S), .SCORE_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_node(wr_node),
        .wr_slot(wr_slot), .wr_valid(wr_valid), .wr_mask(wr_mask),
        .wr_score(wr_score), .start(start), .order(order),
        .done(done), .total_score(total_score)
    );

    int n_checks = 0, n_fail = 0;
    int m_valid [N][S];
    int m_mask  [N][S];
    int m_score [N][S];
    int cur_pos [N];

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int corr(input int d);
        real x;
        if (d >= 64) return 0;
        x = 0.5 * (d / 8) + 0.25;
        return $rtoi(16.0 * $ln(1.0 + $exp(-x)) + 0.5);
    endfunction

    function automatic int logsum(input int a, input int b);
        int hi, lo, r;
        hi = (a >= b) ? a : b;
        lo = (a >= b) ? b : a;
        r = hi + corr(hi - lo);
        if (r > MAXV) r = MAXV;
        return r;
    endfunction

    function automatic int model_total();
        int pos_of [N];
        int tot, pred, acc, have;
        for (int p = 0; p < N; p++) pos_of[cur_pos[p]] = p;
        tot = 0;
        for (int v = 0; v < N; v++) begin
            pred = 0;
            for (int u = 0; u < N; u++)
                if (pos_of[u] < pos_of[v]) pred |= (1 << u);
            have = 0;
            acc = MINV;
            for (int s = 0; s < S; s++) begin
                if (m_valid[v][s] != 0 && (m_mask[v][s] & ~pred) == 0) begin
                    acc = (have != 0) ? logsum(acc, m_score[v][s]) : m_score[v][s];
                    have = 1;
                end
            end
            tot += acc;
        end
        return tot;
    endfunction

    task automatic write_slot(input int n, input int s, input int v, input int m, input int sc);
        @(negedge clk);
        wr_en = 1'b1; wr_node = IDW'(n); wr_slot = SLW'(s);
        wr_valid = (v != 0); wr_mask = N'(m); wr_score = W'(sc);
        @(negedge clk);
        wr_en = 1'b0;
        m_valid[n][s] = v; m_mask[n][s] = m; m_score[n][s] = sc;
    endtask

    task automatic clear_table();
        for (int n = 0; n < N; n++)
            for (int s = 0; s < S; s++)
                write_slot(n, s, 0, 0, 0);
    endtask

    task automatic set_order(input int a, input int b, input int c, input int d);
        cur_pos[0] = a; cur_pos[1] = b; cur_pos[2] = c; cur_pos[3] = d;
    endtask

    task automatic run_order(output int tot, output int lat);
        @(negedge clk);
        for (int p = 0; p < N; p++) order[p*IDW +: IDW] = IDW'(cur_pos[p]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        tot = int'(total_score);
        @(negedge clk);
        check("R7 done width", int'(done), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int tot, lat, exp_x, dones;
        for (int n = 0; n < N; n++)
            for (int s = 0; s < S; s++) begin
                m_valid[n][s] = 0; m_mask[n][s] = 0; m_score[n][s] = 0;
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done after reset", int'(done), 0);
        check("R1 total after reset", int'(total_score), 0);

        // R1/R5: empty table gives the floor for every node
        set_order(0, 1, 2, 3);
        run_order(tot, lat);
        check("R1 R5 empty table", tot, 4 * MINV);
        check("R8 latency", lat, LAT);

        // R3: self and later-node masks are excluded, earlier-node mask kept
        write_slot(0, 0, 1, 4'b0001, 0);
        write_slot(1, 0, 1, 4'b0100, -5);
        write_slot(1, 1, 1, 4'b0001, -7);
        run_order(tot, lat);
        check("R3 exclusion", tot, 3 * MINV - 7);
        check("R3 model", tot, model_total());

        // R4: two empty-mask sets merged by log-sum
        clear_table();
        write_slot(0, 0, 1, 0, -160);
        write_slot(0, 1, 1, 0, -150);
        run_order(tot, lat);
        check("R4 merge", tot, 3 * MINV - 144);
        check("R4 model", tot, model_total());

        // R10: emptying a slot and overwriting a score
        write_slot(0, 1, 0, 0, -150);
        run_order(tot, lat);
        check("R10 emptied slot", tot, 3 * MINV - 160);
        write_slot(0, 0, 1, 0, -170);
        run_order(tot, lat);
        check("R10 overwrite", tot, 3 * MINV - 170);

        // R11: saturation at the largest positive score
        write_slot(0, 0, 1, 0, MAXV);
        write_slot(0, 1, 1, 0, MAXV);
        run_order(tot, lat);
        check("R11 saturation", tot, -65537);
        check("R11 model", tot, model_total());

        // R2/R4/R6: full table swept over every ordering
        clear_table();
        write_slot(0, 0, 1, 4'b0000, -160);
        write_slot(0, 1, 1, 4'b0010, -150);
        write_slot(0, 2, 1, 4'b0110, -170);
        write_slot(1, 0, 1, 4'b0000, -200);
        write_slot(1, 1, 1, 4'b0001, -190);
        write_slot(1, 2, 1, 4'b1001, -205);
        write_slot(1, 3, 1, 4'b0100, -180);
        write_slot(2, 0, 1, 4'b0001, -100);
        write_slot(2, 1, 1, 4'b0100, -10);
        write_slot(2, 2, 1, 4'b1010, -120);
        write_slot(2, 3, 1, 4'b0000, -300);
        write_slot(3, 0, 1, 4'b0001, -50);
        write_slot(3, 1, 1, 4'b0010, -60);
        write_slot(3, 2, 1, 4'b0111, -40);
        for (int a = 0; a < N; a++)
            for (int b = 0; b < N; b++)
                for (int c = 0; c < N; c++)
                    for (int d = 0; d < N; d++) begin
                        if (a != b && a != c && a != d && b != c && b != d && c != d) begin
                            set_order(a, b, c, d);
                            run_order(tot, lat);
                            check("R2 R6 order sweep", tot, model_total());
                            check("R8 sweep latency", lat, LAT);
                        end
                    end

        // R9: a second start mid-run with another ordering is ignored
        set_order(0, 1, 2, 3);
        exp_x = model_total();
        @(negedge clk);
        for (int p = 0; p < N; p++) order[p*IDW +: IDW] = IDW'(p);
        start = 1'b1;
        @(negedge clk);
        for (int p = 0; p < N; p++) order[p*IDW +: IDW] = IDW'(N - 1 - p);
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        dones = 0;
        tot = 0;
        for (int k = 0; k < 12; k++) begin
            if (done) begin
                dones++;
                tot = int'(total_score);
            end
            @(negedge clk);
        end
        check("R9 single done", dones, 1);
        check("R9 captured order", tot, exp_x);

        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule